// File: doc/BRIEF.md
# Single-Bus Multicycle Processor Core

This block is a small 32-bit processor for an eight-operation load/store instruction set. All data movement inside the core goes over one shared internal bus. Each control state selects at most one source for that bus and loads one or more destinations from it. The datapath has one ALU (add, NAND, subtract), a sixteen-entry register file, and the memory-address, instruction, program-counter, two operand and zero-flag registers. A word-addressed memory array sits inside the block. Its depth is a parameter, and it is filled through a preload write port before the core is released from reset.

Each instruction runs as a sequence of bus transfers. A two-state fetch and one decode state come first. An opcode-specific execute sequence follows. Most instructions end with a shared three-transfer program-counter increment. The register file is not addressed from a decoded field. Instead, a 2-bit select from control chooses the A, B or destination field of the instruction register. Equality for the branch is found by subtracting on the ALU and latching the NOR of the result. The bench observes the core through the program counter, a sticky halted flag and a combinational register debug read port.

Top module: `sbus_cpu`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `pc_o` is 0, `halted_o` is 0 and every register reads 0 through the debug port.
- R2: Instruction words use these fields: opcode in bits 19:16, register A in 15:12, register B in 11:8, destination in 3:0, and an 8-bit two's-complement offset in 7:0. Counted from the first fetch cycle, add, nand and an untaken beq take 9 cycles, lw and sw take 10, a taken beq takes 12, jalr takes 7, and a no-operation takes 6. `pc_o` changes only at the end of the last program-counter write of the sequence. At most one bus source is driven in any cycle.
- R3: Opcode 0000 writes A+B, and opcode 0001 writes ~(A&B), into the destination register. A and B are the registers named by fields A and B.
- R4: Opcode 0010 loads register B from the memory word at register A plus the sign-extended offset, using the low address bits. The program counter then advances by one.
- R5: Opcode 0011 stores register B to the memory word at register A plus the sign-extended offset. A later load from that word returns the stored value.
- R6: Opcode 0100 compares registers A and B by subtraction. If they are equal, the program counter becomes PC+1+offset. If not, it becomes PC+1. No register changes.
- R7: Opcode 0101 writes PC+1 into register B and then loads the program counter from register A. When both fields name the same register, the program counter receives the new value, PC+1.
- R8: Opcode 0110 raises `halted_o` three cycles after its fetch begins. From then on, `halted_o` stays high and neither `pc_o` nor any register changes until reset.
- R9: Opcode 0111 and every opcode from 1000 to 1111 only advance the program counter by one.
- R10: `dbg_reg_o` shows the register chosen by `dbg_sel_i` in the same cycle, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pl_we_i | input | 1 | Preload write enable for the memory array |
| pl_addr_i | input | AW | Preload word address |
| pl_data_i | input | W | Preload word data |
| dbg_sel_i | input | RW | Register index for the debug read |
| dbg_reg_o | output | W | Content of the selected register |
| pc_o | output | W | Program counter |
| halted_o | output | 1 | Sticky halted flag |

## Verification
Every result of this core lands on a fixed cycle counted from the first fetch state:
- A new program counter is visible in the first cycle of the next instruction.
- A taken branch shows PC+1 from cycle 9 to cycle 11 before the target appears.
- The halted flag appears in cycle 3 of the halt instruction.

The bench keeps a behavioural model that counts cycles within each instruction and predicts the program counter and halted flag for every clock. It samples both on the falling edge. Register contents are compared through the debug port in cycle 0 of each instruction, when every write of the previous instruction has settled.

// File: rtl/sbus_pkg.sv
`timescale 1ns/1ps
package sbus_pkg;

    // bus sources, one-hot positions in the drive vector
    localparam int NSRC     = 6;
    localparam int SRC_PC   = 0;
    localparam int SRC_MEM  = 1;
    localparam int SRC_REG  = 2;
    localparam int SRC_ALU  = 3;
    localparam int SRC_ONE  = 4;
    localparam int SRC_SEXT = 5;

    // instruction word layout
    localparam int IR_W   = 20;
    localparam int OP_LSB = 16;
    localparam int RA_LSB = 12;
    localparam int RB_LSB = 8;
    localparam int RD_LSB = 0;
    localparam int OFF_W  = 8;

    localparam logic [3:0] OP_ADD  = 4'h0;
    localparam logic [3:0] OP_NAND = 4'h1;
    localparam logic [3:0] OP_LW   = 4'h2;
    localparam logic [3:0] OP_SW   = 4'h3;
    localparam logic [3:0] OP_BEQ  = 4'h4;
    localparam logic [3:0] OP_JALR = 4'h5;
    localparam logic [3:0] OP_HALT = 4'h6;
    localparam logic [3:0] OP_NOOP = 4'h7;

    typedef enum logic [1:0] {FN_ADD = 2'd0, FN_NAND = 2'd1, FN_SUB = 2'd2} alu_fn_e;
    typedef enum logic [1:0] {SEL_RA = 2'd0, SEL_RB = 2'd1, SEL_RD = 2'd2} rsel_e;

    typedef enum logic [3:0] {
        S_F0, S_F1, S_DEC,
        S_X0, S_X1, S_X2, S_X3,
        S_I0, S_I1, S_I2,
        S_B0, S_B1, S_B2,
        S_HALT
    } state_e;

    typedef struct packed {
        logic [NSRC-1:0] drv;
        logic            ld_mar;
        logic            ld_ir;
        logic            ld_pc;
        logic            ld_a;
        logic            ld_b;
        logic            ld_z;
        logic            reg_we;
        logic            mem_we;
        alu_fn_e         fn;
        rsel_e           rsel;
    } ctl_t;

endpackage

// File: rtl/sbus_alu.sv
`timescale 1ns/1ps
module sbus_alu
    import sbus_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_fn_e      fn,
    output logic [W-1:0] y
);

    always_comb begin
        case (fn)
            FN_ADD:  y = a + b;
            FN_NAND: y = ~(a & b);
            FN_SUB:  y = a - b;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/sbus_regfile.sv
`timescale 1ns/1ps
module sbus_regfile #(
    parameter int W    = 32,
    parameter int NREG = 16,
    localparam int RW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [RW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    input  logic [RW-1:0] dbg_addr,
    output logic [W-1:0]  dbg_data
);

    logic [W-1:0] rf_q [NREG];
    logic [W-1:0] rf_d [NREG];

    always_comb begin
        rf_d = rf_q;
        if (we) rf_d[addr] = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) rf_q[i] <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign rdata    = rf_q[addr];
    assign dbg_data = rf_q[dbg_addr];

endmodule

// File: rtl/sbus_mem.sv
`timescale 1ns/1ps
module sbus_mem #(
    parameter int W     = 32,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/sbus_ctrl.sv
`timescale 1ns/1ps
module sbus_ctrl
    import sbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] op,
    input  logic       z,
    output ctl_t       ctl,
    output state_e     st,
    output logic       halted
);

    typedef struct packed {
        state_e st;
        logic   halted;
    } cs_t;

    cs_t cs_q, cs_d;

    always_comb begin
        cs_d     = cs_q;
        ctl      = '0;
        ctl.fn   = FN_ADD;
        ctl.rsel = SEL_RA;
        case (cs_q.st)
            S_F0: begin
                ctl.drv[SRC_PC] = 1'b1; ctl.ld_mar = 1'b1; cs_d.st = S_F1;
            end
            S_F1: begin
                ctl.drv[SRC_MEM] = 1'b1; ctl.ld_ir = 1'b1; cs_d.st = S_DEC;
            end
            S_DEC: begin
                case (op)
                    OP_ADD, OP_NAND, OP_LW, OP_SW, OP_BEQ, OP_JALR: cs_d.st = S_X0;
                    OP_HALT: begin cs_d.st = S_HALT; cs_d.halted = 1'b1; end
                    default: cs_d.st = S_I0;
                endcase
            end
            S_X0: begin
                ctl.ld_a = 1'b1;
                if (op == OP_JALR) ctl.drv[SRC_PC] = 1'b1;
                else begin ctl.drv[SRC_REG] = 1'b1; ctl.rsel = SEL_RA; end
                cs_d.st = S_X1;
            end
            S_X1: begin
                ctl.ld_b = 1'b1;
                case (op)
                    OP_JALR:      ctl.drv[SRC_ONE]  = 1'b1;
                    OP_LW, OP_SW: ctl.drv[SRC_SEXT] = 1'b1;
                    default: begin ctl.drv[SRC_REG] = 1'b1; ctl.rsel = SEL_RB; end
                endcase
                cs_d.st = S_X2;
            end
            S_X2: begin
                ctl.drv[SRC_ALU] = 1'b1;
                case (op)
                    OP_ADD:  begin ctl.reg_we = 1'b1; ctl.rsel = SEL_RD; cs_d.st = S_I0; end
                    OP_NAND: begin ctl.fn = FN_NAND; ctl.reg_we = 1'b1; ctl.rsel = SEL_RD; cs_d.st = S_I0; end
                    OP_LW, OP_SW: begin ctl.ld_mar = 1'b1; cs_d.st = S_X3; end
                    OP_BEQ:  begin ctl.fn = FN_SUB; ctl.ld_z = 1'b1; cs_d.st = S_I0; end
                    OP_JALR: begin ctl.reg_we = 1'b1; ctl.rsel = SEL_RB; cs_d.st = S_X3; end
                    default: cs_d.st = S_I0;
                endcase
            end
            S_X3: begin
                case (op)
                    OP_LW: begin
                        ctl.drv[SRC_MEM] = 1'b1; ctl.reg_we = 1'b1; ctl.rsel = SEL_RB; cs_d.st = S_I0;
                    end
                    OP_SW: begin
                        ctl.drv[SRC_REG] = 1'b1; ctl.rsel = SEL_RB; ctl.mem_we = 1'b1; cs_d.st = S_I0;
                    end
                    OP_JALR: begin
                        ctl.drv[SRC_REG] = 1'b1; ctl.rsel = SEL_RA; ctl.ld_pc = 1'b1; cs_d.st = S_F0;
                    end
                    default: cs_d.st = S_I0;
                endcase
            end
            S_I0: begin ctl.drv[SRC_PC]  = 1'b1; ctl.ld_a = 1'b1; cs_d.st = S_I1; end
            S_I1: begin ctl.drv[SRC_ONE] = 1'b1; ctl.ld_b = 1'b1; cs_d.st = S_I2; end
            S_I2: begin
                ctl.drv[SRC_ALU] = 1'b1; ctl.ld_pc = 1'b1;
                cs_d.st = (op == OP_BEQ && z) ? S_B0 : S_F0;
            end
            S_B0: begin ctl.drv[SRC_PC]   = 1'b1; ctl.ld_a = 1'b1; cs_d.st = S_B1; end
            S_B1: begin ctl.drv[SRC_SEXT] = 1'b1; ctl.ld_b = 1'b1; cs_d.st = S_B2; end
            S_B2: begin ctl.drv[SRC_ALU]  = 1'b1; ctl.ld_pc = 1'b1; cs_d.st = S_F0; end
            S_HALT: cs_d.st = S_HALT;
            default: cs_d.st = S_F0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cs_q <= '{st: S_F0, halted: 1'b0};
        else     cs_q <= cs_d;
    end

    assign st     = cs_q.st;
    assign halted = cs_q.halted;

endmodule

// File: rtl/sbus_cpu.sv
`timescale 1ns/1ps
module sbus_cpu
    import sbus_pkg::*;
#(
    parameter int W     = 32,
    parameter int NREG  = 16,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam int RW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pl_we_i,
    input  logic [AW-1:0] pl_addr_i,
    input  logic [W-1:0]  pl_data_i,
    input  logic [RW-1:0] dbg_sel_i,
    output logic [W-1:0]  dbg_reg_o,
    output logic [W-1:0]  pc_o,
    output logic          halted_o
);

    typedef struct packed {
        logic [AW-1:0]   mar;
        logic [IR_W-1:0] ir;
        logic [W-1:0]    pc;
        logic [W-1:0]    a;
        logic [W-1:0]    b;
        logic            z;
    } dp_t;

    dp_t          dp_q, dp_d;
    ctl_t         ctl;
    state_e       st;
    logic [3:0]   op;
    logic [W-1:0] bus, alu_y, mem_rd, rf_rd;
    logic [W-1:0] src [NSRC];
    logic [RW-1:0] rf_addr;
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [W-1:0]  mem_wdata;

    assign op = dp_q.ir[OP_LSB +: 4];

    sbus_ctrl u_ctrl (
        .clk(clk), .rst(rst), .op(op), .z(dp_q.z),
        .ctl(ctl), .st(st), .halted(halted_o)
    );

    sbus_alu #(.W(W)) u_alu (.a(dp_q.a), .b(dp_q.b), .fn(ctl.fn), .y(alu_y));

    always_comb begin
        case (ctl.rsel)
            SEL_RA:  rf_addr = dp_q.ir[RA_LSB +: RW];
            SEL_RB:  rf_addr = dp_q.ir[RB_LSB +: RW];
            default: rf_addr = dp_q.ir[RD_LSB +: RW];
        endcase
    end

    sbus_regfile #(.W(W), .NREG(NREG)) u_rf (
        .clk(clk), .rst(rst), .we(ctl.reg_we), .addr(rf_addr), .wdata(bus),
        .rdata(rf_rd), .dbg_addr(dbg_sel_i), .dbg_data(dbg_reg_o)
    );

    assign mem_we    = pl_we_i | ctl.mem_we;
    assign mem_waddr = pl_we_i ? pl_addr_i : dp_q.mar;
    assign mem_wdata = pl_we_i ? pl_data_i : bus;

    sbus_mem #(.W(W), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(dp_q.mar), .rdata(mem_rd)
    );

    // shared bus: AND-OR of every source gated by its drive enable
    always_comb begin
        src[SRC_PC]   = dp_q.pc;
        src[SRC_MEM]  = mem_rd;
        src[SRC_REG]  = rf_rd;
        src[SRC_ALU]  = alu_y;
        src[SRC_ONE]  = W'(1);
        src[SRC_SEXT] = {{(W-OFF_W){dp_q.ir[OFF_W-1]}}, dp_q.ir[OFF_W-1:0]};
        bus = '0;
        for (int i = 0; i < NSRC; i++) bus = bus | (src[i] & {W{ctl.drv[i]}});
    end

    always_comb begin
        dp_d = dp_q;
        if (ctl.ld_mar) dp_d.mar = bus[AW-1:0];
        if (ctl.ld_ir)  dp_d.ir  = bus[IR_W-1:0];
        if (ctl.ld_pc)  dp_d.pc  = bus;
        if (ctl.ld_a)   dp_d.a   = bus;
        if (ctl.ld_b)   dp_d.b   = bus;
        if (ctl.ld_z)   dp_d.z   = ~|bus;
    end

    always_ff @(posedge clk) begin
        if (rst) dp_q <= '0;
        else     dp_q <= dp_d;
    end

    assign pc_o = dp_q.pc;

endmodule

module sbus_cpu_chk
    import sbus_pkg::*;
#(
    parameter int W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic [NSRC-1:0] drv,
    input state_e          st,
    input logic [3:0]      op,
    input logic            z,
    input logic [W-1:0]    a,
    input logic [W-1:0]    b,
    input logic [W-1:0]    pc,
    input logic            halted
);

    // R1: reset leaves the core at fetch with a cleared program counter
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (pc == '0 && !halted && st == S_F0));

    // R2: never two bus drivers at once
    a_r2_one_driver: assert property (@(posedge clk) disable iff (rst)
        $onehot0(drv));

    // R2: every transfer state drives exactly one source
    a_r2_transfer_drives: assert property (@(posedge clk) disable iff (rst)
        (st != S_DEC && st != S_HALT) |-> $onehot(drv));

    // R2: the program counter moves only after a state that writes it
    a_r2_pc_write_states: assert property (@(posedge clk) disable iff (rst)
        !$stable(pc) |-> ($past(st) == S_I2 || $past(st) == S_X3 || $past(st) == S_B2));

    // R6: zero flag follows the compare of the operand registers
    a_r6_zero_flag: assert property (@(posedge clk) disable iff (rst)
        (st == S_X2 && op == OP_BEQ) |=> (z == ($past(a) == $past(b))));

    // R8: halt is sticky and freezes the program counter
    a_r8_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(pc)));

    // R9: upper opcodes go straight to the increment sequence
    a_r9_upper_noop: assert property (@(posedge clk) disable iff (rst)
        (st == S_DEC && op[3]) |=> st == S_I0);

endmodule

bind sbus_cpu sbus_cpu_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .drv(ctl.drv), .st(st), .op(op), .z(dp_q.z),
    .a(dp_q.a), .b(dp_q.b), .pc(dp_q.pc), .halted(halted_o)
);

// File: tb/sbus_cpu_test.sv
`timescale 1ns/1ps
module sbus_cpu_test;

    localparam int DEPTH = 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pl_we = 1'b0;
    logic [7:0]  pl_addr = '0;
    logic [31:0] pl_data = '0;
    logic [3:0]  dbg_sel = '0;
    logic [31:0] dbg_reg, pc;
    logic        halted;

    always #4 clk = ~clk;

    sbus_cpu uut (
        .clk(clk), .rst(rst), .pl_we_i(pl_we), .pl_addr_i(pl_addr), .pl_data_i(pl_data),
        .dbg_sel_i(dbg_sel), .dbg_reg_o(dbg_reg), .pc_o(pc), .halted_o(halted)
    );

    int total = 0;
    int bad   = 0;

    logic [31:0] m_reg [16];
    logic [31:0] m_mem [DEPTH];
    logic [31:0] m_pc, m_ir;
    int          k, len, sw_addr;
    bit          taken, is_halt;
    string       pc_tag, rg_tag;

    function automatic logic [31:0] enc(input logic [3:0] op, input logic [3:0] ra,
                                        input logic [3:0] rb, input logic [7:0] lo);
        return {12'h0, op, ra, rb, lo};
    endfunction

    function automatic logic [31:0] sx(input logic [7:0] v);
        return {{24{v[7]}}, v};
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic sweep(input string tag);
        for (int i = 0; i < 16; i++) begin
            dbg_sel = 4'(i);
            #0.2;
            chk(tag, $sformatf("reg%0d", i), dbg_reg, m_reg[i]);
        end
    endtask

    function automatic logic [7:0] m_addr();
        return 8'(m_reg[m_ir[15:12]] + sx(m_ir[7:0]));
    endfunction

    task automatic m_decode();
        m_ir    = m_mem[m_pc[7:0]];
        is_halt = 1'b0;
        taken   = 1'b0;
        pc_tag  = "R2";
        case (m_ir[19:16])
            4'h0, 4'h1: begin len = 9; rg_tag = "R3"; end
            4'h2: begin len = 10; rg_tag = (int'(m_addr()) == sw_addr) ? "R5" : "R4"; end
            4'h3: begin len = 10; rg_tag = "R5"; end
            4'h4: begin
                taken  = (m_reg[m_ir[15:12]] == m_reg[m_ir[11:8]]);
                len    = taken ? 12 : 9;
                pc_tag = "R6"; rg_tag = "R6";
            end
            4'h5: begin len = 7; pc_tag = "R7"; rg_tag = "R7"; end
            4'h6: begin len = 0; is_halt = 1'b1; pc_tag = "R8"; rg_tag = "R8"; end
            default: begin len = 6; pc_tag = "R9"; rg_tag = "R9"; end
        endcase
    endtask

    task automatic m_commit();
        logic [3:0]  ra, rb, rd;
        logic [31:0] nx;
        logic [7:0]  ad;
        ra = m_ir[15:12]; rb = m_ir[11:8]; rd = m_ir[3:0];
        ad = m_addr();
        nx = m_pc + 1;
        case (m_ir[19:16])
            4'h0: begin m_reg[rd] = m_reg[ra] + m_reg[rb];    m_pc = nx; end
            4'h1: begin m_reg[rd] = ~(m_reg[ra] & m_reg[rb]); m_pc = nx; end
            4'h2: begin m_reg[rb] = m_mem[ad]; m_pc = nx; end
            4'h3: begin m_mem[ad] = m_reg[rb]; sw_addr = int'(ad); m_pc = nx; end
            4'h4: m_pc = taken ? nx + sx(m_ir[7:0]) : nx;
            4'h5: begin m_reg[rb] = nx; m_pc = m_reg[ra]; end
            default: m_pc = nx;
        endcase
    endtask

    task automatic run_prog(input int limit);
        int n;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            pl_we = 1'b1; pl_addr = 8'(a); pl_data = m_mem[a];
        end
        @(negedge clk);
        pl_we = 1'b0;
        for (int i = 0; i < 16; i++) m_reg[i] = '0;
        m_pc = '0; k = 0; sw_addr = -1;
        @(negedge clk);
        chk("R1", "pc in reset", pc, 32'h0);
        rst = 1'b0;
        #0.1;
        chk("R1", "pc", pc, 32'h0);
        chk("R1", "halted", {31'b0, halted}, 32'h0);
        sweep("R1");
        m_decode();
        n = 0;
        while (!(is_halt && k >= 25) && n < limit) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            k++;
            if (!is_halt && k == len) begin
                m_commit();
                k = 0;
                sweep(rg_tag);
                m_decode();
            end
            chk(pc_tag, "pc", pc, (taken && k >= 9) ? m_pc + 1 : m_pc);
            chk("R8", "halted", {31'b0, halted}, {31'b0, (is_halt && k >= 3)});
        end
        if (n >= limit) chk("R2", "program did not reach halt", 32'h0, 32'h1);
        sweep("R10");
    endtask

    initial begin
        // program 1: loads, ALU ops, store, both branch outcomes, jalr, loop with negative offset
        for (int a = 0; a < DEPTH; a++) m_mem[a] = '0;
        m_mem[0]  = enc(4'h2, 4'd0, 4'd1, 8'd50);
        m_mem[1]  = enc(4'h2, 4'd0, 4'd2, 8'd51);
        m_mem[2]  = enc(4'h0, 4'd1, 4'd2, 8'd3);
        m_mem[3]  = enc(4'h1, 4'd1, 4'd2, 8'd4);
        m_mem[4]  = enc(4'h3, 4'd0, 4'd3, 8'd52);
        m_mem[5]  = enc(4'h2, 4'd0, 4'd5, 8'd52);
        m_mem[6]  = enc(4'h4, 4'd3, 4'd5, 8'd2);
        m_mem[7]  = enc(4'h6, 4'd0, 4'd0, 8'd0);
        m_mem[8]  = enc(4'h6, 4'd0, 4'd0, 8'd0);
        m_mem[9]  = enc(4'h4, 4'd1, 4'd2, 8'd5);
        m_mem[10] = enc(4'hA, 4'd1, 4'd1, 8'd1);
        m_mem[11] = enc(4'h7, 4'd0, 4'd0, 8'd0);
        m_mem[12] = enc(4'h2, 4'd0, 4'd6, 8'd53);
        m_mem[13] = enc(4'h5, 4'd6, 4'd7, 8'd0);
        m_mem[14] = enc(4'h6, 4'd0, 4'd0, 8'd0);
        m_mem[15] = enc(4'h6, 4'd0, 4'd0, 8'd0);
        m_mem[16] = enc(4'h2, 4'd1, 4'd8, 8'hFD);
        m_mem[17] = enc(4'h4, 4'd0, 4'd0, 8'd1);
        m_mem[18] = enc(4'h6, 4'd0, 4'd0, 8'd0);
        m_mem[19] = enc(4'h0, 4'd8, 4'd7, 8'd9);
        m_mem[20] = enc(4'h2, 4'd0, 4'd10, 8'd54);
        m_mem[21] = enc(4'h2, 4'd0, 4'd11, 8'd55);
        m_mem[22] = enc(4'h0, 4'd10, 4'd11, 8'd10);
        m_mem[23] = enc(4'h4, 4'd10, 4'd0, 8'd1);
        m_mem[24] = enc(4'h4, 4'd0, 4'd0, 8'hFD);
        m_mem[25] = enc(4'h6, 4'd0, 4'd0, 8'd0);
        m_mem[50] = 32'd5;
        m_mem[51] = 32'h8000_0007;
        m_mem[53] = 32'd16;
        m_mem[54] = 32'd3;
        m_mem[55] = 32'hFFFF_FFFF;
        run_prog(2000);

        // program 2: jalr with same register, negative store offset, upper opcode
        for (int a = 0; a < DEPTH; a++) m_mem[a] = '0;
        m_mem[0]  = enc(4'h2, 4'd0, 4'd1, 8'd40);
        m_mem[1]  = enc(4'h5, 4'd1, 4'd1, 8'd0);
        m_mem[2]  = enc(4'h3, 4'd1, 4'd1, 8'hFF);
        m_mem[3]  = enc(4'h2, 4'd0, 4'd2, 8'd1);
        m_mem[4]  = enc(4'hF, 4'd2, 4'd2, 8'd2);
        m_mem[5]  = enc(4'h6, 4'd0, 4'd0, 8'd0);
        m_mem[40] = 32'd30;
        run_prog(1000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule